// File: doc/BRIEF.md
# Multithreaded Control Register Bank

This block is the control register bank of one processor core that runs up to eight hardware threads. Software reaches it by sub-register index: a read request carries an index and a thread number and returns one 32-bit word. A write request carries an index, a thread number and a data word. Some sub-registers exist once per core. Others exist once per thread, and the thread number picks the copy.

The bank holds the tile and core identifiers and a merged global identifier. It has a 64-bit cycle counter that starts at reset and is read as two halves. It counts data and instruction cache misses for the whole core and data misses for each thread. It also holds a mask of the threads that are active, the program counter of each thread, the status and trap cause of each thread, two argument slots and the cache write-policy bit. Hardware events come in on dedicated inputs: miss strobes, trap events and status updates from the pipeline. The write-policy bit also drives an output pin for the cache controller.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset every counter, both argument slots, the write-policy bit, every thread status and every trap cause read as zero. Status zero means idle.
- R2: Index 0 returns the tile ID and index 1 the core ID, both zero-extended. Index 2 returns the read thread number. Index 3 returns {tile, core, thread} with the tile in the top bits. Index 14 returns the number of hardware threads.
- R3: The 64-bit cycle counter adds one on every clock after reset. Index 4 returns its low 32 bits and index 5 its high 32 bits.
- R4: Each data-miss strobe adds one to the core data-miss count (index 7) and to the per-thread miss count of the tagged thread (index 15). Each instruction-miss strobe adds one to index 8.
- R5: Index 9 returns the program counter input of the read thread.
- R6: A trap event with cause 1 (scratchpad misalignment) or cause 2 (load/store misalignment) sets that thread's status to 3 (trapped) and stores the cause at index 10. Trap events with cause 0 or 3 are ignored.
- R7: Status codes are 0 idle, 1 running, 2 end, 3 trapped and 4 waiting at a barrier. The status of a thread comes from one of three sources, in this priority: a trap event, then the pipeline status update, then a software write to index 11. A status value above 4 from either of the last two sources is ignored.
- R8: Indices 12 and 13 are full 32-bit read/write argument slots. Index 16 keeps bit 0 of the written word as the write policy (0 write-back, 1 write-through). It reads back as that bit alone and drives `wt_mode_o`.
- R9: A write to any index other than 11, 12, 13 or 16 changes nothing. A read of indices 17 to 31 returns zero.
- R10: Index 6 returns a mask with bit t set when thread t is running (1) or waiting at a barrier (4).
- R11: Reads are combinational from the index and thread inputs. A write shows on the read port only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tile_id_i | input | TILE_BITS | Tile identifier |
| core_id_i | input | CORE_BITS | Core identifier |
| pc_i | input | NUM_THREADS*32 | Program counter of each thread, thread 0 in the low word |
| dmiss_i | input | 1 | Data cache miss strobe |
| dmiss_tid_i | input | TID_W | Thread that caused the data miss |
| imiss_i | input | 1 | Instruction cache miss strobe |
| trap_valid_i | input | 1 | Trap event strobe |
| trap_tid_i | input | TID_W | Thread that trapped |
| trap_cause_i | input | 2 | Trap cause code |
| stat_upd_i | input | 1 | Pipeline status update strobe |
| stat_upd_tid_i | input | TID_W | Thread whose status is updated |
| stat_upd_val_i | input | 3 | New status code |
| wr_en_i | input | 1 | Software write request |
| wr_idx_i | input | 5 | Write sub-register index |
| wr_tid_i | input | TID_W | Write thread number |
| wr_data_i | input | 32 | Write data |
| rd_idx_i | input | 5 | Read sub-register index |
| rd_tid_i | input | TID_W | Read thread number |
| rd_data_o | output | 32 | Read data |
| wt_mode_o | output | 1 | Write-policy bit, 1 = write-through |

## Verification
Per-thread indices are read from several threads after activity on only some of them. This shows whether the thread number selects the right copy or a neighbour leaks in. Miss strobes are given an uneven spread over threads, with instruction misses mixed in, so that a swapped counter or a wrong thread tag gives a different count. For status, the trap, the pipeline update and the software write are made to collide on one thread, and then two of them on another, which tells the priority order apart. Illegal status values and illegal trap causes are applied and must leave the state as it was. Writes to read-only and undefined indices are followed by reads of every writable slot. These reads show that nothing moved.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int CR_DATA_W = 32;
  localparam int CR_IDX_W  = 5;

  localparam logic [CR_IDX_W-1:0] IX_TILE   = 5'd0;
  localparam logic [CR_IDX_W-1:0] IX_CORE   = 5'd1;
  localparam logic [CR_IDX_W-1:0] IX_THREAD = 5'd2;
  localparam logic [CR_IDX_W-1:0] IX_GLOBAL = 5'd3;
  localparam logic [CR_IDX_W-1:0] IX_CNT_LO = 5'd4;
  localparam logic [CR_IDX_W-1:0] IX_CNT_HI = 5'd5;
  localparam logic [CR_IDX_W-1:0] IX_ENMASK = 5'd6;
  localparam logic [CR_IDX_W-1:0] IX_DMISS  = 5'd7;
  localparam logic [CR_IDX_W-1:0] IX_IMISS  = 5'd8;
  localparam logic [CR_IDX_W-1:0] IX_PC     = 5'd9;
  localparam logic [CR_IDX_W-1:0] IX_CAUSE  = 5'd10;
  localparam logic [CR_IDX_W-1:0] IX_STATUS = 5'd11;
  localparam logic [CR_IDX_W-1:0] IX_ARGC   = 5'd12;
  localparam logic [CR_IDX_W-1:0] IX_ARGV   = 5'd13;
  localparam logic [CR_IDX_W-1:0] IX_NTHR   = 5'd14;
  localparam logic [CR_IDX_W-1:0] IX_TMISS  = 5'd15;
  localparam logic [CR_IDX_W-1:0] IX_WPOL   = 5'd16;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_END  = 3'd2,
    ST_TRAP = 3'd3,
    ST_WAIT = 3'd4
  } thr_state_e;

  // A status word is legal when it encodes one of the five states.
  function automatic logic f_state_ok(input logic [CR_DATA_W-1:0] v);
    return v <= CR_DATA_W'(ST_WAIT);
  endfunction

  // Only the two misalignment causes are recorded.
  function automatic logic f_cause_ok(input logic [1:0] c);
    return (c == 2'd1) || (c == 2'd2);
  endfunction

  // A thread counts as enabled while running or parked at a barrier.
  function automatic logic f_runnable(input thr_state_e s);
    return (s == ST_RUN) || (s == ST_WAIT);
  endfunction
endpackage

// File: rtl/ctlreg_gcounter.sv
module ctlreg_gcounter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      run_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q - $past(cnt_q)) == CNT_W'(1));
endmodule

// File: rtl/ctlreg_thread_slot.sv
module ctlreg_thread_slot
  import ctlreg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trap_hit_i,
  input  logic [1:0]           trap_cause_i,
  input  logic                 hw_upd_i,
  input  logic [2:0]           hw_val_i,
  input  logic                 sw_wr_i,
  input  logic [2:0]           sw_val_i,
  input  logic                 dmiss_hit_i,
  output thr_state_e           state_o,
  output logic [1:0]           cause_o,
  output logic [CR_DATA_W-1:0] miss_o
);
  thr_state_e           st_q;
  logic [1:0]           cause_q;
  logic [CR_DATA_W-1:0] miss_q;
  logic                 any_upd;

  assign any_upd = trap_hit_i || hw_upd_i || sw_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cause_q <= 2'd0;
      miss_q  <= '0;
    end else begin
      if (trap_hit_i) begin
        st_q    <= ST_TRAP;
        cause_q <= trap_cause_i;
      end else if (hw_upd_i) begin
        st_q <= thr_state_e'(hw_val_i);
      end else if (sw_wr_i) begin
        st_q <= thr_state_e'(sw_val_i);
      end
      if (dmiss_hit_i) miss_q <= miss_q + 1'b1;
    end
  end

  assign state_o = st_q;
  assign cause_o = cause_q;
  assign miss_o  = miss_q;

  p_trap_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit_i |=> (st_q == ST_TRAP));
  p_cause_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q != 2'd3);
  p_legal_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_q <= ST_WAIT);
  p_state_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !any_upd |=> $stable(st_q));
  p_miss_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dmiss_hit_i |=> $stable(miss_q));
endmodule

// File: rtl/ctlreg_rd_mux.sv
module ctlreg_rd_mux
  import ctlreg_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int TILE_BITS   = 8,
  parameter int CORE_BITS   = 8,
  parameter int TID_W       = 3
) (
  input  logic [CR_IDX_W-1:0]              rd_idx_i,
  input  logic [TID_W-1:0]                 rd_tid_i,
  input  logic [TILE_BITS-1:0]             tile_id_i,
  input  logic [CORE_BITS-1:0]             core_id_i,
  input  logic [63:0]                      gcnt_i,
  input  logic [NUM_THREADS-1:0]           en_mask_i,
  input  logic [CR_DATA_W-1:0]             dmiss_cnt_i,
  input  logic [CR_DATA_W-1:0]             imiss_cnt_i,
  input  logic [NUM_THREADS*CR_DATA_W-1:0] pc_i,
  input  thr_state_e                       st_i    [NUM_THREADS],
  input  logic [1:0]                       cause_i [NUM_THREADS],
  input  logic [CR_DATA_W-1:0]             miss_i  [NUM_THREADS],
  input  logic [CR_DATA_W-1:0]             argc_i,
  input  logic [CR_DATA_W-1:0]             argv_i,
  input  logic                             wpol_i,
  output logic [CR_DATA_W-1:0]             rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    unique case (rd_idx_i)
      IX_TILE:   rd_data_o = CR_DATA_W'(tile_id_i);
      IX_CORE:   rd_data_o = CR_DATA_W'(core_id_i);
      IX_THREAD: rd_data_o = CR_DATA_W'(rd_tid_i);
      IX_GLOBAL: rd_data_o = CR_DATA_W'({tile_id_i, core_id_i, rd_tid_i});
      IX_CNT_LO: rd_data_o = gcnt_i[31:0];
      IX_CNT_HI: rd_data_o = gcnt_i[63:32];
      IX_ENMASK: rd_data_o = CR_DATA_W'(en_mask_i);
      IX_DMISS:  rd_data_o = dmiss_cnt_i;
      IX_IMISS:  rd_data_o = imiss_cnt_i;
      IX_PC:     rd_data_o = pc_i[rd_tid_i*CR_DATA_W +: CR_DATA_W];
      IX_CAUSE:  rd_data_o = CR_DATA_W'(cause_i[rd_tid_i]);
      IX_STATUS: rd_data_o = CR_DATA_W'(st_i[rd_tid_i]);
      IX_ARGC:   rd_data_o = argc_i;
      IX_ARGV:   rd_data_o = argv_i;
      IX_NTHR:   rd_data_o = CR_DATA_W'(NUM_THREADS);
      IX_TMISS:  rd_data_o = miss_i[rd_tid_i];
      IX_WPOL:   rd_data_o = CR_DATA_W'(wpol_i);
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int TILE_BITS   = 8,
  parameter int CORE_BITS   = 8,
  parameter int TID_W       = $clog2(NUM_THREADS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [TILE_BITS-1:0]             tile_id_i,
  input  logic [CORE_BITS-1:0]             core_id_i,
  input  logic [NUM_THREADS*CR_DATA_W-1:0] pc_i,
  input  logic                             dmiss_i,
  input  logic [TID_W-1:0]                 dmiss_tid_i,
  input  logic                             imiss_i,
  input  logic                             trap_valid_i,
  input  logic [TID_W-1:0]                 trap_tid_i,
  input  logic [1:0]                       trap_cause_i,
  input  logic                             stat_upd_i,
  input  logic [TID_W-1:0]                 stat_upd_tid_i,
  input  logic [2:0]                       stat_upd_val_i,
  input  logic                             wr_en_i,
  input  logic [CR_IDX_W-1:0]              wr_idx_i,
  input  logic [TID_W-1:0]                 wr_tid_i,
  input  logic [CR_DATA_W-1:0]             wr_data_i,
  input  logic [CR_IDX_W-1:0]              rd_idx_i,
  input  logic [TID_W-1:0]                 rd_tid_i,
  output logic [CR_DATA_W-1:0]             rd_data_o,
  output logic                             wt_mode_o
);
  localparam int GID_W = TILE_BITS + CORE_BITS + TID_W;

  // Named write strobes, visible to the assertions.
  logic wr_argc, wr_argv, wr_wpol, wr_status, trap_ok, upd_ok, sw_ok;

  logic [CR_DATA_W-1:0] argc_q, argv_q, dmiss_cnt_q, imiss_cnt_q;
  logic                 wpol_q;
  logic [63:0]          gcnt;

  thr_state_e           st_a    [NUM_THREADS];
  logic [1:0]           cause_a [NUM_THREADS];
  logic [CR_DATA_W-1:0] miss_a  [NUM_THREADS];
  logic [NUM_THREADS-1:0] en_mask;

  assign wr_argc   = wr_en_i && (wr_idx_i == IX_ARGC);
  assign wr_argv   = wr_en_i && (wr_idx_i == IX_ARGV);
  assign wr_wpol   = wr_en_i && (wr_idx_i == IX_WPOL);
  assign wr_status = wr_en_i && (wr_idx_i == IX_STATUS);
  assign trap_ok   = trap_valid_i && f_cause_ok(trap_cause_i);
  assign upd_ok    = stat_upd_i && f_state_ok(CR_DATA_W'(stat_upd_val_i));
  assign sw_ok     = wr_status && f_state_ok(wr_data_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      argc_q      <= '0;
      argv_q      <= '0;
      wpol_q      <= 1'b0;
      dmiss_cnt_q <= '0;
      imiss_cnt_q <= '0;
    end else begin
      if (wr_argc) argc_q <= wr_data_i;
      if (wr_argv) argv_q <= wr_data_i;
      if (wr_wpol) wpol_q <= wr_data_i[0];
      if (dmiss_i) dmiss_cnt_q <= dmiss_cnt_q + 1'b1;
      if (imiss_i) imiss_cnt_q <= imiss_cnt_q + 1'b1;
    end
  end

  ctlreg_gcounter #(.CNT_W(64)) u_gcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_o (gcnt)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic hit_trap, hit_upd, hit_sw, hit_miss;
    assign hit_trap = trap_ok && (trap_tid_i == TID_W'(t));
    assign hit_upd  = upd_ok && (stat_upd_tid_i == TID_W'(t));
    assign hit_sw   = sw_ok && (wr_tid_i == TID_W'(t));
    assign hit_miss = dmiss_i && (dmiss_tid_i == TID_W'(t));

    ctlreg_thread_slot u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .trap_hit_i   (hit_trap),
      .trap_cause_i (trap_cause_i),
      .hw_upd_i     (hit_upd),
      .hw_val_i     (stat_upd_val_i),
      .sw_wr_i      (hit_sw),
      .sw_val_i     (wr_data_i[2:0]),
      .dmiss_hit_i  (hit_miss),
      .state_o      (st_a[t]),
      .cause_o      (cause_a[t]),
      .miss_o       (miss_a[t])
    );

    assign en_mask[t] = f_runnable(st_a[t]);
  end

  ctlreg_rd_mux #(
    .NUM_THREADS (NUM_THREADS),
    .TILE_BITS   (TILE_BITS),
    .CORE_BITS   (CORE_BITS),
    .TID_W       (TID_W)
  ) u_rd_mux (
    .rd_idx_i    (rd_idx_i),
    .rd_tid_i    (rd_tid_i),
    .tile_id_i   (tile_id_i),
    .core_id_i   (core_id_i),
    .gcnt_i      (gcnt),
    .en_mask_i   (en_mask),
    .dmiss_cnt_i (dmiss_cnt_q),
    .imiss_cnt_i (imiss_cnt_q),
    .pc_i        (pc_i),
    .st_i        (st_a),
    .cause_i     (cause_a),
    .miss_i      (miss_a),
    .argc_i      (argc_q),
    .argv_i      (argv_q),
    .wpol_i      (wpol_q),
    .rd_data_o   (rd_data_o)
  );

  assign wt_mode_o = wpol_q;

  initial begin
    assert (GID_W <= CR_DATA_W) else $error("global ID does not fit one word");
  end

  p_ro_argc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_argc |=> $stable(argc_q));
  p_ro_wpol_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_wpol |=> $stable(wt_mode_o));
  p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_i > IX_WPOL) |-> (rd_data_o == '0));
  p_dmiss_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dmiss_i |=> $stable(dmiss_cnt_q));
  p_imiss_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    imiss_i |=> (imiss_cnt_q == $past(imiss_cnt_q) + 1'b1));
  p_wpol_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wpol |=> (wt_mode_o == $past(wr_data_i[0])));
endmodule

// File: tb/ctlreg_bank_bench.sv
module ctlreg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int TW = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        tile_id = 8'hA5, core_id = 8'h3C;
  logic [NT*32-1:0]  pc = '0;
  logic              dmiss = 0, imiss = 0, trap_v = 0, upd = 0, wr_en = 0;
  logic [TW-1:0]     dmiss_tid = 0, trap_tid = 0, upd_tid = 0, wr_tid = 0, rd_tid = 0;
  logic [1:0]        trap_cause = 0;
  logic [2:0]        upd_val = 0;
  logic [4:0]        wr_idx = 0, rd_idx = 0;
  logic [31:0]       wr_data = 0, rd_data;
  logic              wt_mode;

  int checks = 0, fails = 0;
  bit finished = 0;
  int exp_st [NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlreg_bank u_ctlreg_bank (
    .clk(clk), .rst_n(rst_n), .tile_id_i(tile_id), .core_id_i(core_id), .pc_i(pc),
    .dmiss_i(dmiss), .dmiss_tid_i(dmiss_tid), .imiss_i(imiss),
    .trap_valid_i(trap_v), .trap_tid_i(trap_tid), .trap_cause_i(trap_cause),
    .stat_upd_i(upd), .stat_upd_tid_i(upd_tid), .stat_upd_val_i(upd_val),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tid_i(wr_tid), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_tid_i(rd_tid), .rd_data_o(rd_data), .wt_mode_o(wt_mode)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic rd(input int idx, input int tid, output logic [31:0] v);
    rd_idx = 5'(idx); rd_tid = TW'(tid);
    #1 v = rd_data;
  endtask

  task automatic rd_chk(input string tag, input int idx, input int tid, input logic [31:0] exp);
    logic [31:0] v;
    rd(idx, tid, v);
    chk(tag, v, exp);
  endtask

  task automatic sw_write(input int idx, input int tid, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(idx); wr_tid = TW'(tid); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset;
    for (int t = 0; t < NT; t++) begin
      rd_chk("R1 status", 11, t, 0);
      rd_chk("R1 cause", 10, t, 0);
      rd_chk("R1 tmiss", 15, t, 0);
    end
    rd_chk("R1 dmiss", 7, 0, 0);
    rd_chk("R1 imiss", 8, 0, 0);
    rd_chk("R1 argc", 12, 0, 0);
    rd_chk("R1 argv", 13, 0, 0);
    rd_chk("R1 wpol", 16, 0, 0);
    chk("R1 wt pin", 32'(wt_mode), 0);
    rd_chk("R1 cnt high", 5, 0, 0);
  endtask

  task automatic t_ids;
    rd_chk("R2 tile", 0, 0, 32'h0A5);
    rd_chk("R2 core", 1, 0, 32'h03C);
    rd_chk("R2 nthreads", 14, 0, NT);
    for (int t = 0; t < NT; t += 3) begin
      rd_chk("R2 tid", 2, t, t);
      rd_chk("R2 global", 3, t, (32'hA5 << 11) | (32'h3C << 3) | t);
    end
  endtask

  task automatic t_counter;
    logic [31:0] a, b;
    @(negedge clk); rd(4, 0, a);
    repeat (17) @(negedge clk);
    rd(4, 0, b);
    chk("R3 low delta", b - a, 17);
    rd_chk("R3 high", 5, 0, 0);
  endtask

  task automatic t_miss;
    int seq [6] = '{2, 2, 5, 2, 7, 5};
    foreach (seq[i]) begin
      @(negedge clk);
      dmiss = 1; dmiss_tid = TW'(seq[i]);
      imiss = (i % 2 == 0);
    end
    @(negedge clk); dmiss = 0; imiss = 0;
    rd_chk("R4 dmiss", 7, 0, 6);
    rd_chk("R4 imiss", 8, 0, 3);
    rd_chk("R4 tmiss t2", 15, 2, 3);
    rd_chk("R4 tmiss t5", 15, 5, 2);
    rd_chk("R4 tmiss t7", 15, 7, 1);
    rd_chk("R4 tmiss t0", 15, 0, 0);
  endtask

  task automatic t_pc;
    for (int t = 0; t < NT; t++) pc[t*32 +: 32] = 32'h1000_0000 + t * 32'h44;
    for (int t = 0; t < NT; t++) rd_chk("R5 pc", 9, t, 32'h1000_0000 + t * 32'h44);
  endtask

  task automatic t_trap;
    @(negedge clk); trap_v = 1; trap_tid = 3; trap_cause = 2'd1;
    @(negedge clk); trap_tid = 6; trap_cause = 2'd2;
    @(negedge clk); trap_tid = 0; trap_cause = 2'd3;
    @(negedge clk); trap_tid = 1; trap_cause = 2'd0;
    @(negedge clk); trap_v = 0;
    exp_st[3] = 3; exp_st[6] = 3;
    rd_chk("R6 status t3", 11, 3, 3);
    rd_chk("R6 cause t3", 10, 3, 1);
    rd_chk("R6 status t6", 11, 6, 3);
    rd_chk("R6 cause t6", 10, 6, 2);
    rd_chk("R6 ignored cause3", 11, 0, 0);
    rd_chk("R6 ignored cause3 reason", 10, 0, 0);
    rd_chk("R6 ignored cause0", 11, 1, 0);
  endtask

  task automatic t_status;
    // All three sources on thread 1: trap wins.
    @(negedge clk);
    trap_v = 1; trap_tid = 1; trap_cause = 2'd2;
    upd = 1; upd_tid = 1; upd_val = 3'd2;
    wr_en = 1; wr_idx = 11; wr_tid = 1; wr_data = 4;
    @(negedge clk);
    trap_v = 0;
    // Update and software on thread 4: update wins.
    upd_tid = 4; upd_val = 3'd1; wr_tid = 4; wr_data = 2;
    @(negedge clk);
    upd = 0;
    wr_tid = 0; wr_data = 4;     // software only on thread 0
    @(negedge clk);
    wr_tid = 2; wr_data = 5;     // illegal value
    @(negedge clk);
    wr_en = 0; upd = 1; upd_tid = 7; upd_val = 3'd6; // illegal update
    @(negedge clk);
    upd_val = 3'd2;              // legal end on thread 7
    @(negedge clk);
    upd = 0;
    exp_st[1] = 3; exp_st[4] = 1; exp_st[0] = 4; exp_st[7] = 2;
    rd_chk("R7 trap beats others", 11, 1, 3);
    rd_chk("R7 update beats sw", 11, 4, 1);
    rd_chk("R7 sw write", 11, 0, 4);
    rd_chk("R7 illegal sw ignored", 11, 2, 0);
    rd_chk("R7 end state", 11, 7, 2);
  endtask

  task automatic t_enable;
    logic [31:0] m = 0;
    for (int t = 0; t < NT; t++) if (exp_st[t] == 1 || exp_st[t] == 4) m[t] = 1'b1;
    rd_chk("R10 enable mask", 6, 0, m);
  endtask

  task automatic t_shared;
    sw_write(12, 5, 32'hDEAD_BEEF);
    sw_write(13, 1, 32'h8000_1234);
    sw_write(16, 0, 32'hFFFF_FFF1);
    rd_chk("R8 argc", 12, 0, 32'hDEAD_BEEF);
    rd_chk("R8 argv", 13, 7, 32'h8000_1234);
    rd_chk("R8 wpol wt", 16, 0, 1);
    chk("R8 wt pin", 32'(wt_mode), 1);
    sw_write(16, 0, 32'h2);
    rd_chk("R8 wpol wb", 16, 0, 0);
    chk("R8 wt pin wb", 32'(wt_mode), 0);
  endtask

  task automatic t_readonly;
    int ro [6] = '{0, 4, 7, 10, 15, 20};
    foreach (ro[i]) sw_write(ro[i], 3, 32'h5555_5555);
    rd_chk("R9 tile kept", 0, 0, 32'hA5);
    rd_chk("R9 dmiss kept", 7, 0, 6);
    rd_chk("R9 cause kept", 10, 3, 1);
    rd_chk("R9 tmiss kept", 15, 3, 0);
    rd_chk("R9 argc kept", 12, 0, 32'hDEAD_BEEF);
    rd_chk("R9 argv kept", 13, 0, 32'h8000_1234);
    rd_chk("R9 wpol kept", 16, 0, 0);
    for (int ix = 17; ix < 32; ix += 7) rd_chk("R9 undefined index", ix, 0, 0);
    rd_chk("R9 undefined 31", 31, 2, 0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    wr_en = 1; wr_idx = 12; wr_data = 32'h0000_0007;
    rd_chk("R11 before edge", 12, 0, 32'hDEAD_BEEF);
    @(posedge clk); #1;
    wr_en = 0;
    rd_chk("R11 after edge", 12, 0, 7);
  endtask

  initial begin
    for (int t = 0; t < NT; t++) exp_st[t] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ids();
    t_counter();
    t_miss();
    t_pc();
    t_trap();
    t_status();
    t_enable();
    t_shared();
    t_readonly();
    t_timing();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule